// File: doc/BRIEF.md
# Second-Operand Shifter Field Decoder

This block takes a 32-bit data-processing instruction word and works out how its second operand is formed. The operand can be an 8-bit constant rotated inside the word, or a source register with a shift applied. For the register case the shift amount comes either from a 5-bit constant in the instruction or from a second register. The block reports which form applies, the constant after rotation, the register indices, the shift kind, where the amount comes from, and whether an extra internal cycle is needed to read the amount register.

Two zero-amount encodings have their own meaning, and the block resolves both. A constant left shift by zero means the register is used unshifted. A constant rotate by zero means a one-bit rotate right through the carry flag. Neither rule applies when the amount comes from a register. The block does not shift any data and does no other decoding.

An instruction word is accepted in every cycle that `in_valid` is high. The decoded fields appear on registered outputs one clock later, together with `out_valid`. The outputs hold their values until the next accepted word.

Top module: `opnd2_decoder`

## Requirements
- R1: While `rst` is high, and after its release, `out_valid` is 0 and every decoded field is 0 until the first word is accepted.
- R2: A word presented with `in_valid` high produces its decoded fields and `out_valid` = 1 exactly one clock later. Back-to-back words give back-to-back results. With `in_valid` low, `out_valid` drops to 0 and the fields keep their last values.
- R3: Instruction bit 25 selects the form: 1 means rotated constant, 0 means shifted register. In the constant form, `out_is_imm` is 1 and `out_rm`, `out_rs`, `out_amt`, `out_amt_is_reg` and `out_extra_cycle` are 0. `out_shift` is 0 (none).
- R4: In the constant form, `out_imm` equals bits 7:0, zero-extended to 32 bits and rotated right by twice the value in bits 11:8. This holds for all sixteen rotate values.
- R5: In the register form, `out_imm` is 0 and `out_rm` equals bits 3:0. Bits 6:5 give the shift kind, which is reported on `out_shift` with these codes: 00 gives LSL (1), 01 gives LSR (2), 10 gives ASR (3) and 11 gives ROR (4). The remaining codes are 0 for none and 5 for RRX.
- R6: In the register form with bit 4 set, `out_amt_is_reg` = 1, `out_rs` = bits 11:8, `out_amt` = 0 and `out_extra_cycle` = 1. The shift kind is reported exactly as encoded, even when bits 11:8 are zero.
- R7: In the register form with bit 4 clear, `out_amt` = bits 11:7. In that case `out_amt_is_reg`, `out_rs` and `out_extra_cycle` are all 0.
- R8: In the register form with bit 4 clear, a left shift with a zero amount is reported as none (code 0).
- R9: In the register form with bit 4 clear, a rotate with a zero amount is reported as RRX (code 5).
- R10: In the register form with bit 4 clear, a logical or arithmetic right shift with a zero amount is reported as its encoded kind (2 or 3), with `out_amt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is presented this cycle |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded fields belong to the word accepted one cycle earlier |
| out_is_imm | output | 1 | 1 for the rotated-constant form |
| out_imm | output | 32 | Rotated constant |
| out_rm | output | 4 | Source register index |
| out_shift | output | 3 | Shift kind code: 0 none, 1 LSL, 2 LSR, 3 ASR, 4 ROR, 5 RRX |
| out_amt_is_reg | output | 1 | 1 when the shift amount comes from a register |
| out_rs | output | 4 | Shift-amount register index |
| out_amt | output | 5 | Constant shift amount |
| out_extra_cycle | output | 1 | One additional internal cycle is required |

## Verification
The interaction most likely to go wrong is a zero-amount check meeting a register-specified amount in the same word. With bit 4 set and bits 11:7 zero, the constant amount field reads zero while the amount register is index 0. A decoder that tests the amount field without checking bit 4 will turn LSL into none, or ROR into RRX, while still flagging the extra cycle. The bench provokes this by sending register-amount words with amount register 0 for all four shift kinds, alternating with constant-amount words that use zero amounts. The scoreboard then judges every field of each result against values computed from the requirements.

// File: rtl/opnd2_pkg.sv
package opnd2_pkg;
  // Shift kind codes reported on the decoder output.
  typedef enum logic [2:0] {
    SH_NONE = 3'd0,
    SH_LSL  = 3'd1,
    SH_LSR  = 3'd2,
    SH_ASR  = 3'd3,
    SH_ROR  = 3'd4,
    SH_RRX  = 3'd5
  } shift_e;

  // Field positions inside the instruction word.
  localparam int POS_FORM_SEL = 25;
  localparam int POS_AMT_SRC  = 4;
  localparam int POS_KIND_LO  = 5;
  localparam int POS_RS_LO    = 8;
  localparam int POS_AMT_LO   = 7;
  localparam int POS_ROT_LO   = 8;
  localparam int OPND_FIELD_W = 12;
endpackage

// File: rtl/opnd2_imm_rot.sv
module opnd2_imm_rot #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm8,
  input  logic [ROT_W-1:0] rot,
  output logic [XLEN-1:0]  value
);
  localparam int AMT_W = ROT_W + 1;

  logic [AMT_W-1:0]  amt;
  logic [XLEN-1:0]   base;
  logic [2*XLEN-1:0] twin;
  logic [2*XLEN-1:0] moved;

  // The rotate amount is twice the field: append a zero bit.
  assign amt   = {rot, 1'b0};
  assign base  = {{(XLEN-IMM_W){1'b0}}, imm8};
  // Shifting two copies of the word right gives the rotate in the low half.
  assign twin  = {base, base};
  assign moved = twin >> amt;
  assign value = moved[XLEN-1:0];

  logic unused_hi;
  assign unused_hi = ^moved[2*XLEN-1:XLEN];
endmodule

// File: rtl/opnd2_reg_field.sv
module opnd2_reg_field
  import opnd2_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int SAMT_W = 5
) (
  input  logic [OPND_FIELD_W-1:0] fld,
  output logic [REG_W-1:0]        rm,
  output shift_e                  kind,
  output logic                    amt_is_reg,
  output logic [REG_W-1:0]        rs,
  output logic [SAMT_W-1:0]       amt,
  output logic                    extra
);
  logic              by_reg;
  logic [SAMT_W-1:0] amt_field;
  shift_e            coded;

  assign by_reg    = fld[POS_AMT_SRC];
  assign amt_field = fld[POS_AMT_LO +: SAMT_W];
  assign rm        = fld[REG_W-1:0];

  always_comb begin
    unique case (fld[POS_KIND_LO +: 2])
      2'd0:    coded = SH_LSL;
      2'd1:    coded = SH_LSR;
      2'd2:    coded = SH_ASR;
      default: coded = SH_ROR;
    endcase
  end

  always_comb begin
    kind = coded;
    // The zero-amount special encodings apply only to constant amounts.
    if (!by_reg && (amt_field == '0)) begin
      if (coded == SH_LSL) kind = SH_NONE;
      if (coded == SH_ROR) kind = SH_RRX;
    end
  end

  assign amt_is_reg = by_reg;
  assign extra      = by_reg;
  assign rs         = by_reg ? fld[POS_RS_LO +: REG_W] : '0;
  assign amt        = by_reg ? '0 : amt_field;
endmodule

// File: rtl/opnd2_decoder.sv
module opnd2_decoder
  import opnd2_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int REG_W  = 4,
  parameter int SAMT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   in_instr,
  output logic              out_valid,
  output logic              out_is_imm,
  output logic [XLEN-1:0]   out_imm,
  output logic [REG_W-1:0]  out_rm,
  output logic [2:0]        out_shift,
  output logic              out_amt_is_reg,
  output logic [REG_W-1:0]  out_rs,
  output logic [SAMT_W-1:0] out_amt,
  output logic              out_extra_cycle
);
  logic                    form_imm;
  logic [OPND_FIELD_W-1:0] fld;
  logic [XLEN-1:0]         rot_val;
  logic [REG_W-1:0]        r_rm, r_rs;
  shift_e                  r_kind;
  logic                    r_amt_is_reg, r_extra;
  logic [SAMT_W-1:0]       r_amt;

  assign form_imm = in_instr[POS_FORM_SEL];
  assign fld      = in_instr[OPND_FIELD_W-1:0];

  opnd2_imm_rot #(.XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm8  (fld[IMM_W-1:0]),
    .rot   (fld[POS_ROT_LO +: ROT_W]),
    .value (rot_val)
  );

  opnd2_reg_field #(.REG_W(REG_W), .SAMT_W(SAMT_W)) u_regf (
    .fld        (fld),
    .rm         (r_rm),
    .kind       (r_kind),
    .amt_is_reg (r_amt_is_reg),
    .rs         (r_rs),
    .amt        (r_amt),
    .extra      (r_extra)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_is_imm      <= 1'b0;
      out_imm         <= '0;
      out_rm          <= '0;
      out_shift       <= 3'(SH_NONE);
      out_amt_is_reg  <= 1'b0;
      out_rs          <= '0;
      out_amt         <= '0;
      out_extra_cycle <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_is_imm      <= form_imm;
        out_imm         <= form_imm ? rot_val : '0;
        out_rm          <= form_imm ? '0 : r_rm;
        out_shift       <= form_imm ? 3'(SH_NONE) : 3'(r_kind);
        out_amt_is_reg  <= !form_imm && r_amt_is_reg;
        out_rs          <= form_imm ? '0 : r_rs;
        out_amt         <= form_imm ? '0 : r_amt;
        out_extra_cycle <= !form_imm && r_extra;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{in_instr[XLEN-1:POS_FORM_SEL+1], in_instr[POS_FORM_SEL-1:OPND_FIELD_W]};

  // R2: the result shows one cycle after acceptance
  p_accept_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_lat_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_imm) && $stable(out_shift));
  // R3: constant form leaves the register fields clear
  p_imm_form_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && form_imm |=> out_is_imm && out_shift == 3'(SH_NONE) && !out_extra_cycle && out_rm == '0);
  // R4: rotation keeps the set bits of the constant
  p_rot_bits_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && form_imm |=> $countones(out_imm) == $countones($past(in_instr[IMM_W-1:0])));
  // R6: register amount costs one extra cycle and keeps the encoded kind
  p_reg_amt_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && !form_imm && in_instr[POS_AMT_SRC] |=>
      out_extra_cycle && out_amt_is_reg && out_rs == $past(in_instr[POS_RS_LO +: REG_W])
      && out_shift != 3'(SH_NONE) && out_shift != 3'(SH_RRX));
  // R8: constant LSL by zero is no shift
  p_lsl_zero_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && !form_imm && !in_instr[POS_AMT_SRC] && in_instr[6:5] == 2'd0
      && in_instr[11:7] == 5'd0 |=> out_shift == 3'(SH_NONE));
  // R9: constant ROR by zero is RRX
  p_ror_zero_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && !form_imm && !in_instr[POS_AMT_SRC] && in_instr[6:5] == 2'd3
      && in_instr[11:7] == 5'd0 |=> out_shift == 3'(SH_RRX));
endmodule

// File: tb/opnd2_decoder_tb_top.sv
module opnd2_decoder_tb_top;
  localparam int RES_W = 51;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        out_valid, out_is_imm, out_amt_is_reg, out_extra_cycle;
  logic [31:0] out_imm;
  logic [3:0]  out_rm, out_rs;
  logic [2:0]  out_shift;
  logic [4:0]  out_amt;

  int checks = 0;
  int errors = 0;

  logic [RES_W-1:0] exp_q[$];
  string            tag_q[$];
  logic [RES_W-1:0] last_exp = '0;

  always #2 clk = ~clk;

  opnd2_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(out_valid), .out_is_imm(out_is_imm), .out_imm(out_imm),
    .out_rm(out_rm), .out_shift(out_shift), .out_amt_is_reg(out_amt_is_reg),
    .out_rs(out_rs), .out_amt(out_amt), .out_extra_cycle(out_extra_cycle)
  );

  function automatic logic [RES_W-1:0] observed();
    return {out_is_imm, out_imm, out_rm, out_shift, out_amt_is_reg, out_rs, out_amt, out_extra_cycle};
  endfunction

  // Reference rotate: one bit position at a time.
  function automatic logic [31:0] ref_rot(input logic [7:0] b, input int steps);
    logic [31:0] v = {24'd0, b};
    for (int i = 0; i < steps; i++) v = {v[0], v[31:1]};
    return v;
  endfunction

  function automatic logic [RES_W-1:0] expect_of(input logic [31:0] w);
    logic        is_imm = w[25];
    logic [31:0] imm = '0;
    logic [3:0]  rm = '0, rs = '0;
    logic [2:0]  sh = 3'd0;
    logic        areg = 1'b0, extra = 1'b0;
    logic [4:0]  amt = '0;
    if (is_imm) begin
      imm = ref_rot(w[7:0], 2 * int'(w[11:8]));
    end else begin
      rm = w[3:0];
      sh = 3'(w[6:5]) + 3'd1;
      if (w[4]) begin
        areg = 1'b1; extra = 1'b1; rs = w[11:8];
      end else begin
        amt = w[11:7];
        if (amt == 5'd0 && w[6:5] == 2'd0) sh = 3'd0;
        if (amt == 5'd0 && w[6:5] == 2'd3) sh = 3'd5;
      end
    end
    return {is_imm, imm, rm, sh, areg, rs, amt, extra};
  endfunction

  task automatic check(input string req, input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input string req);
    @(negedge clk);
    exp_q.push_back(expect_of(w));
    tag_q.push_back(req);
    last_exp = expect_of(w);
    in_instr = w;
    in_valid = 1'b1;
  endtask

  // Monitor: compare each result against the queue head.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected result", observed(), '1);
      end else begin
        automatic logic [RES_W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, observed(), e);
      end
    end
  end

  function automatic logic [31:0] regw(input logic [1:0] k, input logic by_reg,
                                        input logic [4:0] a, input logic [3:0] s, input logic [3:0] m);
    logic [11:0] f = by_reg ? {s, 1'b0, k, 1'b1, m} : {a, k, 1'b0, m};
    return 32'hE001_5000 | {20'd0, f};
  endfunction

  task automatic run();
    repeat (3) @(negedge clk);
    check("R1 reset state", {out_valid, observed()}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {out_valid, observed()}, '0);
    // R4 / R3: all sixteen rotates, constant form
    for (int r = 0; r < 16; r++)
      drive(32'hE200_0000 | (r << 8) | ((8'hA5 ^ (r * 8'd17)) & 8'hFF), "R4 R3 rotate");
    drive(32'hE200_0F81, "R4 rotate wrap");
    // R5 R7 R8 R9 R10: constant amounts, zero, one, max
    for (int k = 0; k < 4; k++) begin
      drive(regw(2'(k), 1'b0, 5'd0,  4'd0, 4'd9), "R8 R9 R10 zero amount");
      drive(regw(2'(k), 1'b0, 5'd1,  4'd0, 4'd3), "R5 R7 amount one");
      drive(regw(2'(k), 1'b0, 5'd31, 4'd0, 4'd15), "R5 R7 amount max");
    end
    // R6: register amounts, amount register 0 against zero-amount rules
    for (int k = 0; k < 4; k++) begin
      drive(regw(2'(k), 1'b1, 5'd0, 4'd0,  4'd7), "R6 rs zero");
      drive(regw(2'(k), 1'b0, 5'd0, 4'd0,  4'd7), "R8 R9 R10 interleaved");
      drive(regw(2'(k), 1'b1, 5'd0, 4'd13, 4'd2), "R6 rs nonzero");
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    // R2: idle leaves the last result in place
    check("R2 hold", {out_valid, observed()}, {1'b0, last_exp});
    check("R2 drained", RES_W'(exp_q.size()), '0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule